// File: doc/BRIEF.md
# Frame Sync and Error Flag Generator

This block divides the crystal-rate clock down to a frame-rate square wave and uses that wave to time-share a single flag pin between two per-frame decoder status bits. With the default 16.9344 MHz clock and a half period of 1152 clocks, the square wave runs at 7.35 kHz.

At each frame boundary, the first- and second-stage correction status bits from the decoder are captured. During the low half of the frame, the flag pin shows the first-stage status. During the high half, it shows the second-stage status. A host that watches the flag during the high half can judge how much the second correction stage is being used.

Top module: `fsync_eflag_gen`

## Requirements
- R1: While `rst_n` is low, `fsync` and `eflag` are both 0.
- R2: `fsync` is low for `HALF_CYCLES` clocks and then high for `HALF_CYCLES` clocks, repeating with a period of 2*`HALF_CYCLES`. After reset is released, the first frame begins low. Counting rising edges since release as k, `fsync` is high exactly when (k mod 2*`HALF_CYCLES`) >= `HALF_CYCLES`.
- R3: While `fsync` is low, `eflag` equals the value of `c1_err` captured at the start of the current frame.
- R4: While `fsync` is high, `eflag` equals the value of `c2_err` captured at the start of the current frame.
- R5: Status inputs are captured only on the rising edge that starts a frame, which is when k is a nonzero multiple of 2*`HALF_CYCLES`. A change on `c1_err` or `c2_err` at any other time has no effect on `eflag` within the current frame.
- R6: During the first frame after reset, `eflag` is 0 whatever the status inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c1_err | input | 1 | First-stage correction status for the frame |
| c2_err | input | 1 | Second-stage correction status for the frame |
| fsync | output | 1 | Frame sync square wave |
| eflag | output | 1 | Multiplexed status flag |

## Verification
A divider count that is wrong shows up at the first half boundary it reaches, as an `fsync` edge one or more clocks early or late. The bench therefore samples the clocks on each side of both edges in a frame.

Capture registers that are wrongly latched, or that are loaded at the wrong time, show up within one frame. In that case `eflag` either follows an input that changed mid-frame or keeps the previous frame's value. Each of the four status patterns is run with a mid-frame input flip to expose this.

// File: rtl/fsync_eflag_gen.sv
module fsync_eflag_gen #(
  parameter int HALF_CYCLES = 1152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic c1_err,
  input  logic c2_err,
  output logic fsync,
  output logic eflag
);
  localparam int PERIOD = 2 * HALF_CYCLES;
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF_CYCLES);

  logic [CW-1:0] cnt;
  logic          c1_q, c2_q;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      c1_q <= 1'b0;
      c2_q <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        c1_q <= c1_err;
        c2_q <= c2_err;
      end
    end
  end

  assign fsync = rst_n && (cnt >= MID);
  assign eflag = rst_n && (fsync ? c2_q : c1_q);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync != $past(fsync)) |-> (cnt == '0 || cnt == MID));

  // R5
  flag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && cnt != MID) |-> $stable(eflag));

  // R3
  c1_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(rst_n)) |-> (c1_q == $past(c1_err)));

  // R4
  c2_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(rst_n)) |-> (c2_q == $past(c2_err)));
endmodule

// File: tb/sim_fsync_eflag_gen.sv
module sim_fsync_eflag_gen;
  localparam int HALF = 1152;
  localparam int P = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c1_err = 1'b0;
  logic c2_err = 1'b0;
  logic fsync, eflag;
  int k = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else k <= k + 1;
  end

  fsync_eflag_gen #(.HALF_CYCLES(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .c1_err(c1_err), .c2_err(c2_err),
    .fsync(fsync), .eflag(eflag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at k=%0d: got %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic goto(input int target);
    while (k != target) @(negedge clk);
  endtask

  task automatic t_reset();
    c1_err = 1'b1;
    c2_err = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 fsync", fsync, 1'b0);
    chk("R1 eflag", eflag, 1'b0);
  endtask

  task automatic t_first_frame();
    rst_n = 1'b1;
    goto(5);
    chk("R2 first low", fsync, 1'b0);
    chk("R6 low half", eflag, 1'b0);
    goto(HALF + 5);
    chk("R6 high half", eflag, 1'b0);
    goto(P + 3);
    chk("R3 after first capture", eflag, 1'b1);
  endtask

  task automatic t_period();
    int base = ((k / P) + 1) * P;
    int lows = 0;
    goto(base);
    chk("R2 frame start low", fsync, 1'b0);
    for (int i = 0; i < P; i++) begin
      if (fsync === 1'b0) lows++;
      if (i == HALF - 1) chk("R2 last low", fsync, 1'b0);
      if (i == HALF) chk("R2 first high", fsync, 1'b1);
      if (i == P - 1) chk("R2 last high", fsync, 1'b1);
      @(negedge clk);
    end
    chk("R2 next frame low", fsync, 1'b0);
    checks++;
    if (lows != HALF) begin
      errors++;
      $display("FAIL R2 low count: got %0d expected %0d", lows, HALF);
    end
  endtask

  task automatic t_pattern(input logic a, input logic b);
    int base = ((k / P) + 1) * P;
    c1_err = a;
    c2_err = b;
    goto(base + 1);
    chk("R3 early low", eflag, a);
    goto(base + 10);
    c1_err = ~a;
    c2_err = ~b;
    goto(base + HALF - 1);
    chk("R5 low after flip", eflag, a);
    goto(base + HALF);
    chk("R4 early high", eflag, b);
    goto(base + P - 1);
    chk("R5 high after flip", eflag, b);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_frame();
        t_period();
        t_pattern(1'b0, 1'b0);
        t_pattern(1'b1, 1'b0);
        t_pattern(1'b0, 1'b1);
        t_pattern(1'b1, 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule